// File: doc/BRIEF.md
# Single-Channel Block Copy Engine with Bus-Sharing Policies

This block moves a block of bytes between a byte-wide device port and main memory while the processor gets on with other work. Software loads a memory address and a byte count, then writes the control word. The control word selects the direction and one of three policies for sharing the memory bus with the processor, and it sets the start bit. The engine then copies the block one byte at a time. It raises a level interrupt when the last byte has been moved and keeps it high until software clears it.

The bus-sharing policy decides how engine accesses interleave with processor accesses. In burst policy the engine holds its bus request from start to finish. In cycle-stealing policy it requests the bus separately for every byte and drops the request between bytes. In transparent policy it never requests the bus and uses memory only in cycles where the processor reports that the bus is idle.

Top module: `dma_mover`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `bus_req`, `mem_valid`, `dev_in_ready` and `dev_out_valid` are low.
- R2: Register decode uses `reg_addr[3:2]`. Offset 0 holds the memory address and offset 4 the byte count. Offset 8 is control: bit 0 start (reads as 0), bit 1 direction (1 = device to memory, 0 = memory to device), bits 3:2 policy (0 burst, 1 cycle stealing, 2 transparent, 3 behaves as burst). Offset 12 is status: bit 0 busy, bit 1 done.
- R3: In device-to-memory direction, the n-th byte accepted on the device input is written to memory at start address + n.
- R4: In memory-to-device direction, the byte read at start address + n is the n-th byte presented on the device output, and it is held stable until accepted.
- R5: Each completed memory access adds one to the address register and subtracts one from the count register. At the end the address reads start + count and the count reads 0.
- R6: When the block ends, busy clears and done and `irq` rise and stay high. Writing 1 to status bit 1 clears both.
- R7: A start with a count of zero sets done directly, without ever asserting `bus_req` or touching memory.
- R8: While busy, writes to offsets 0, 4 and 8 have no effect, including a second start.
- R9: In burst policy, `bus_req` is asserted once and stays high until the block ends.
- R10: In cycle-stealing policy, `bus_req` rises once per byte and is low for at least one cycle after every memory access.
- R11: In transparent policy, `bus_req` stays low, and memory accesses take place only in cycles where `cpu_bus_active` is low.
- R12: In burst and cycle-stealing policy, a memory access takes place only in a cycle where `bus_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| bus_req | output | 1 | Memory bus request to the arbiter |
| bus_gnt | input | 1 | Memory bus grant |
| cpu_bus_active | input | 1 | Processor is using the bus this cycle |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ready` |
| dev_in_valid | input | 1 | Device input byte available |
| dev_in_data | input | 8 | Device input byte |
| dev_in_ready | output | 1 | Engine accepts a device byte |
| dev_out_valid | output | 1 | Engine offers a byte to the device |
| dev_out_data | output | 8 | Byte offered to the device |
| dev_out_ready | input | 1 | Device accepts the byte |
| irq | output | 1 | Completion interrupt, level |

## Verification
The embedded properties assume an arbiter that grants the bus only to a pending request. They also assume a memory that completes an access in the cycle `mem_ready` is high and returns read data in that same cycle. The bench's arbiter derives `bus_grant` as `bus_req` ANDed with a random enable. Its memory model answers reads combinationally from its array. The ready, valid, grant and processor-activity inputs are driven randomly, always on the falling edge, so the engine sees stalls in every state without those assumptions being broken.

// File: rtl/dma_mover.sv
module dma_mover #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  input  logic          cpu_bus_active,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ready,
  input  logic [7:0]    mem_rdata,
  input  logic          dev_in_valid,
  input  logic [7:0]    dev_in_data,
  output logic          dev_in_ready,
  output logic          dev_out_valid,
  output logic [7:0]    dev_out_data,
  input  logic          dev_out_ready,
  output logic          irq
);

  typedef enum logic [1:0] {S_IDLE, S_DEV, S_MEM, S_PUT} state_t;

  state_t        state;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic          dir_q;
  logic [1:0]    mode_q;
  logic          busy_q, done_q;
  logic [7:0]    buf_q;

  logic [1:0] sel;
  logic       wr_addr, wr_len, wr_ctrl, start, clr_done;
  logic       steal, transp, allowed, mem_hs, out_hs, in_hs, last_in, finish;

  assign sel      = reg_addr[3:2];
  assign wr_addr  = reg_we && sel == 2'd0 && !busy_q;
  assign wr_len   = reg_we && sel == 2'd1 && !busy_q;
  assign wr_ctrl  = reg_we && sel == 2'd2 && !busy_q;
  assign start    = wr_ctrl && reg_wdata[0];
  assign clr_done = reg_we && sel == 2'd3 && reg_wdata[1];

  assign steal   = mode_q == 2'd1;
  assign transp  = mode_q == 2'd2;
  assign allowed = transp ? !cpu_bus_active : bus_gnt;

  assign bus_req   = busy_q && !transp && (!steal || state == S_MEM);
  assign mem_valid = state == S_MEM && allowed;
  assign mem_hs    = mem_valid && mem_ready;
  assign mem_write = dir_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = buf_q;

  assign dev_in_ready  = state == S_DEV;
  assign in_hs         = dev_in_ready && dev_in_valid;
  assign dev_out_valid = state == S_PUT;
  assign dev_out_data  = buf_q;
  assign out_hs        = dev_out_valid && dev_out_ready;

  assign last_in = mem_hs && dir_q && len_q == LW'(1);
  assign finish  = last_in || (out_hs && len_q == '0);
  assign irq     = done_q;

  always_comb begin
    case (sel)
      2'd0:    reg_rdata = 32'(addr_q);
      2'd1:    reg_rdata = 32'(len_q);
      2'd2:    reg_rdata = {28'd0, mode_q, dir_q, 1'b0};
      default: reg_rdata = {30'd0, done_q, busy_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      len_q  <= '0;
      dir_q  <= 1'b0;
      mode_q <= 2'd0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (wr_addr) addr_q <= AW'(reg_wdata);
      if (wr_len)  len_q  <= LW'(reg_wdata);
      if (wr_ctrl) begin
        dir_q  <= reg_wdata[1];
        mode_q <= reg_wdata[3:2];
      end
      if (clr_done) done_q <= 1'b0;
      if (start) begin
        if (len_q == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          state  <= reg_wdata[1] ? S_DEV : S_MEM;
        end
      end
      case (state)
        S_DEV: if (in_hs) begin
          buf_q <= dev_in_data;
          state <= S_MEM;
        end
        S_MEM: if (mem_hs) begin
          addr_q <= addr_q + AW'(1);
          len_q  <= len_q - LW'(1);
          if (!dir_q) begin
            buf_q <= mem_rdata;
            state <= S_PUT;
          end else begin
            state <= S_DEV;
          end
        end
        S_PUT: if (out_hs) state <= S_MEM;
        default: ;
      endcase
      if (finish) begin
        state  <= S_IDLE;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hs |=> addr_q == $past(addr_q) + AW'(1));

  a_r5_len_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hs |=> len_q == $past(len_q) - LW'(1));

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !clr_done && !start |=> done_q);

  a_r8_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !mem_hs |=> $stable(addr_q) && $stable(mode_q) && $stable(dir_q));

  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid && !dev_out_ready |=> dev_out_valid && $stable(dev_out_data));

  a_r9_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !steal && !transp |=> bus_req || done_q);

  a_r10_steal_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hs && steal |=> !bus_req);

  a_r12_granted: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hs && !transp |-> bus_req && bus_gnt);

  a_r7_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start && len_q == '0 |=> !busy_q && done_q && !bus_req);

endmodule

// File: tb/dma_mover_bench.sv
module dma_mover_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_req, bus_gnt, mem_valid, mem_write, mem_ready;
  logic        cpu_bus_active, gnt_en;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, dev_in_data, dev_out_data;
  logic        dev_in_valid, dev_in_ready, dev_out_valid, dev_out_ready, irq;

  logic [7:0] mem [0:255];
  logic [7:0] src [0:63];
  logic [7:0] sink [0:63];
  int src_idx, sink_cnt;
  int checks = 0, fails = 0;
  int req_rises, req_cycles, clash, nogrant;
  bit req_q, mon_on;

  always #2 clk = ~clk;

  dma_mover u_dma_mover (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .cpu_bus_active(cpu_bus_active), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .dev_in_valid(dev_in_valid),
    .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_ready(dev_out_ready), .irq(irq));

  assign bus_gnt     = bus_req && gnt_en;
  assign mem_rdata   = mem[mem_addr[7:0]];
  assign dev_in_data = src[src_idx[5:0]];

  initial begin
    mem_ready = 0; gnt_en = 0; cpu_bus_active = 0; dev_in_valid = 0; dev_out_ready = 0;
  end

  always @(negedge clk) begin
    mem_ready      <= ($urandom % 4) != 0;
    gnt_en         <= ($urandom % 3) != 0;
    cpu_bus_active <= ($urandom % 2) != 0;
    dev_in_valid   <= ($urandom % 3) != 0;
    dev_out_ready  <= ($urandom % 3) != 0;
  end

  always @(posedge clk) begin
    if (mem_valid && mem_ready && mem_write) mem[mem_addr[7:0]] <= mem_wdata;
    if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 1;
    if (dev_out_valid && dev_out_ready) begin
      sink[sink_cnt[5:0]] <= dev_out_data;
      sink_cnt <= sink_cnt + 1;
    end
    if (mon_on) begin
      if (bus_req && !req_q) req_rises <= req_rises + 1;
      if (bus_req) req_cycles <= req_cycles + 1;
      if (mem_valid && mem_ready && cpu_bus_active) clash <= clash + 1;
      if (mem_valid && mem_ready && !bus_gnt) nogrant <= nogrant + 1;
    end
    req_q <= bus_req;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] pat(int s, int i);
    return 8'((s * 37 + i * 11 + 5) ^ (i << 3));
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_mon;
    req_rises = 0; req_cycles = 0; clash = 0; nogrant = 0;
  endtask

  task automatic run_xfer(int s, int base, int len, int dir, int mode, bit poke);
    logic [31:0] v;
    int bad, eff, t;
    for (int i = 0; i < len; i++) begin
      if (dir == 0) mem[(base + i) & 255] = pat(s, i);
      else src[i] = pat(s, i);
    end
    src_idx = 0; sink_cnt = 0;
    wr(4'd0, 32'(base));
    wr(4'd4, 32'(len));
    clear_mon();
    mon_on = 1;
    wr(4'd8, 32'((mode << 2) | (dir << 1) | 1));
    if (poke) begin
      rd(4'd12, v);
      check(v[0] == 1'b1, "R2 busy bit", v, 1);
      wr(4'd0, 32'h77);
      wr(4'd4, 32'd3);
      wr(4'd8, 32'hD);
    end
    t = 0;
    while (!irq && t < 4000) begin @(negedge clk); t++; end
    check(irq == 1'b1, "R6 irq at end", irq, 1);
    @(negedge clk);
    mon_on = 0;
    bad = 0;
    for (int i = 0; i < len; i++) begin
      if (dir == 1 && mem[(base + i) & 255] != pat(s, i)) bad++;
      if (dir == 0 && sink[i] != pat(s, i)) bad++;
    end
    if (dir == 1) begin
      check(bad == 0, "R3 memory contents", bad, 0);
      check(src_idx == len, "R3 bytes taken", src_idx, len);
    end else begin
      check(bad == 0, "R4 device bytes", bad, 0);
      check(sink_cnt == len, "R4 bytes given", sink_cnt, len);
    end
    rd(4'd0, v);
    check(v == 32'(base + len), poke ? "R8 R5 address" : "R5 address", v, base + len);
    rd(4'd4, v);
    check(v == 0, poke ? "R8 R5 count" : "R5 count", v, 0);
    rd(4'd8, v);
    check(v == 32'((mode << 2) | (dir << 1)), "R2 control readback", v, (mode << 2) | (dir << 1));
    rd(4'd12, v);
    check(v == 32'd2, "R6 status done", v, 2);
    eff = (mode == 3) ? 0 : mode;
    if (eff == 0) check(req_rises == 1, "R9 single request", req_rises, 1);
    if (eff == 1) check(req_rises == len, "R10 request per byte", req_rises, len);
    if (eff == 2) begin
      check(req_cycles == 0, "R11 no request", req_cycles, 0);
      check(clash == 0, "R11 idle cycles only", clash, 0);
    end else begin
      check(nogrant == 0, "R12 granted access", nogrant, 0);
    end
    wr(4'd12, 32'd2);
    rd(4'd12, v);
    check(v == 0 && irq == 0, "R6 done cleared", {v[1:0], irq}, 0);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1C0FFEE));
    mon_on = 0; src_idx = 0; sink_cnt = 0; req_q = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    clear_mon();
    repeat (4) @(negedge clk);
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), v);
      check(v == 0, "R1 register reset", v, 0);
    end
    check(!irq && !bus_req && !mem_valid && !dev_in_ready && !dev_out_valid,
          "R1 outputs idle", {irq, bus_req, mem_valid, dev_in_ready, dev_out_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    rd(4'd12, v);
    check(v == 0 && !irq, "R1 after release", v, 0);

    run_xfer(1, 16, 5, 1, 0, 0);
    run_xfer(2, 40, 6, 0, 0, 0);
    run_xfer(3, 80, 4, 1, 1, 0);
    run_xfer(4, 100, 7, 0, 1, 0);
    run_xfer(5, 120, 6, 1, 2, 0);
    run_xfer(6, 140, 5, 0, 2, 0);
    run_xfer(7, 250, 10, 1, 3, 1);
    run_xfer(8, 60, 12, 0, 1, 1);
    run_xfer(9, 0, 1, 0, 0, 0);

    clear_mon();
    mon_on = 1;
    wr(4'd4, 32'd0);
    wr(4'd8, 32'd3);
    rd(4'd12, v);
    mon_on = 0;
    check(v == 32'd2 && irq, "R7 zero count done", v, 2);
    check(req_cycles == 0, "R7 no bus request", req_cycles, 0);
    wr(4'd12, 32'd2);

    for (int k = 0; k < 14; k++) begin
      run_xfer(20 + k, int'($urandom % 200), 1 + int'($urandom % 40),
               int'($urandom % 2), int'($urandom % 4), ($urandom % 3) == 0 ? 1'b0 : 1'b0);
    end
    for (int k = 0; k < 4; k++) begin
      run_xfer(40 + k, int'($urandom % 200), 10 + int'($urandom % 30),
               int'($urandom % 2), k, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule